// File: doc/BRIEF.md
# Integer ALU with Set-Less-Than and Equality Flag

This block is the execute-stage arithmetic-logic unit of a small load/store RISC core. It is purely combinational. It takes two 32-bit operands, a 5-bit shift distance and a 4-bit operation code. It produces a 32-bit result and a flag that is high when that result is all zeros.

The supported operations are add, subtract, AND, OR and NOR. There are two set-less-than compares, one signed and one unsigned. There is also a logical left shift. Bitwise inversion is obtained by issuing NOR with a zero second operand.

A branch unit decides equal and not-equal branches by issuing a subtract and reading the zero flag. Adder, compare, logic and shift paths are separate submodules. The output multiplexer in the top module picks one of them.

Top module: `int_alu`

## Requirements
- R1: Code 0 (add) returns the low 32 bits of opnd_a + opnd_b; the carry out of bit 31 is discarded.
- R2: Code 1 (subtract) returns the low 32 bits of opnd_a + ~opnd_b + 1.
- R3: Code 2 returns opnd_a & opnd_b and code 3 returns opnd_a | opnd_b, bit by bit.
- R4: Code 4 returns ~(opnd_a | opnd_b); with opnd_b zero this is the bitwise inverse of opnd_a.
- R5: Code 5 returns 1 when opnd_a < opnd_b as two's-complement values and 0 otherwise, with bits 31..1 zero. This holds also for operand pairs whose difference overflows, such as 0x80000000 against 0x7FFFFFFF.
- R6: Code 6 returns 1 when opnd_a < opnd_b as unsigned values and 0 otherwise, with bits 31..1 zero; 0xFFFFFFFF against 0x00000001 gives 0.
- R7: Code 7 returns opnd_a shifted left by shamt (0 to 31), with zeros entering at bit 0; opnd_b does not affect the result.
- R8: The zero output is 1 exactly when the 32-bit result is all zeros, for every code; for a subtract it is therefore 1 exactly when the operands are equal.
- R9: Codes 8 to 15 return a result of zero, so the zero output is 1.
- R10: shamt has no effect on the result of any code other than 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First operand; the value shifted by code 7 |
| opnd_b | input | 32 | Second operand |
| shamt | input | 5 | Left-shift distance used by code 7 |
| op_sel | input | 4 | Operation code, 0..7 as listed in the requirements |
| result | output | 32 | Selected operation result |
| zero | output | 1 | High when result is all zeros |

## Verification
The zero flag and the compare results are produced in the same evaluation as the arithmetic. The equality decision rides on the subtract that produces the difference. The set-less-than outputs come from the same shared adder, and they can legitimately be zero.

The bench makes these coincide in three ways. It feeds equal operands to subtract and to both compares. It feeds disjoint masks to AND. It feeds unused codes. Each time it judges the 32-bit result and the flag together against a reference computed from the requirements. Random operands include a quarter of pairs with identical values, so equality and the extreme signed pairs recur across every code.

// File: rtl/int_alu_pkg.sv
`timescale 1ns/1ps
package int_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_NOR  = 4'd4,
    OP_SLT  = 4'd5,
    OP_SLTU = 4'd6,
    OP_SLL  = 4'd7
  } alu_op_e;

  // Signed overflow of an addition given the sign bits of both addends and the sum.
  function automatic logic add_overflow(input logic a_msb, input logic b_msb, input logic s_msb);
    return (a_msb == b_msb) && (s_msb != a_msb);
  endfunction

  // Signed less-than from a subtraction: sign of difference corrected by overflow.
  function automatic logic signed_less(input logic diff_msb, input logic ovf);
    return diff_msb ^ ovf;
  endfunction

  // Unsigned less-than from a subtraction: no carry out means a borrow occurred.
  function automatic logic unsigned_less(input logic carry_out);
    return ~carry_out;
  endfunction

  // Adder path subtracts for subtract and both compares.
  function automatic logic needs_subtract(input logic [3:0] op);
    return (op == OP_SUB) || (op == OP_SLT) || (op == OP_SLTU);
  endfunction

endpackage

// File: rtl/int_alu_addsub.sv
`timescale 1ns/1ps
module int_alu_addsub
  import int_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  input  logic              sub_en,
  output logic [DATA_W-1:0] sum_out,
  output logic              carry_out,
  output logic              ovf_out
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   wide_sum;

  assign b_eff     = sub_en ? ~b_in : b_in;
  assign wide_sum  = {1'b0, a_in} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub_en};
  assign sum_out   = wide_sum[MSB:0];
  assign carry_out = wide_sum[DATA_W];
  assign ovf_out   = add_overflow(a_in[MSB], b_eff[MSB], wide_sum[MSB]);

endmodule

// File: rtl/int_alu_logic.sv
`timescale 1ns/1ps
module int_alu_logic #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_in,
  input  logic [DATA_W-1:0] b_in,
  output logic [DATA_W-1:0] and_out,
  output logic [DATA_W-1:0] or_out,
  output logic [DATA_W-1:0] nor_out
);

  assign and_out = a_in & b_in;
  assign or_out  = a_in | b_in;
  assign nor_out = ~or_out;

endmodule

// File: rtl/int_alu_shift.sv
`timescale 1ns/1ps
module int_alu_shift #(
  parameter int DATA_W = 32,
  localparam int SH_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] din,
  input  logic [SH_W-1:0]   amt,
  output logic [DATA_W-1:0] dout
);

  logic [DATA_W-1:0] stage [0:SH_W];

  assign stage[0] = din;

  // One conditional power-of-two shift per bit of the distance.
  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    localparam int STEP = 1 << k;
    assign stage[k+1] = amt[k] ? {stage[k][DATA_W-1-STEP:0], {STEP{1'b0}}} : stage[k];
  end

  assign dout = stage[SH_W];

endmodule

// File: rtl/int_alu_cmp.sv
`timescale 1ns/1ps
module int_alu_cmp
  import int_alu_pkg::*;
(
  input  logic diff_msb,
  input  logic diff_ovf,
  input  logic diff_carry,
  output logic lt_signed,
  output logic lt_unsigned
);

  assign lt_signed   = signed_less(diff_msb, diff_ovf);
  assign lt_unsigned = unsigned_less(diff_carry);

endmodule

// File: rtl/int_alu.sv
`timescale 1ns/1ps
module int_alu
  import int_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SH_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [SH_W-1:0]   shamt,
  input  logic [3:0]        op_sel,
  output logic [DATA_W-1:0] result,
  output logic              zero
);

  localparam int MSB = DATA_W - 1;

  // Named internal events, visible to the bound checker.
  logic              sub_mode;
  logic [DATA_W-1:0] arith_sum;
  logic              arith_carry;
  logic              arith_ovf;
  logic [DATA_W-1:0] and_res, or_res, nor_res;
  logic [DATA_W-1:0] shl_res;
  logic              lt_s, lt_u;

  assign sub_mode = needs_subtract(op_sel);

  int_alu_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a_in      (opnd_a),
    .b_in      (opnd_b),
    .sub_en    (sub_mode),
    .sum_out   (arith_sum),
    .carry_out (arith_carry),
    .ovf_out   (arith_ovf)
  );

  int_alu_logic #(.DATA_W(DATA_W)) u_logic (
    .a_in    (opnd_a),
    .b_in    (opnd_b),
    .and_out (and_res),
    .or_out  (or_res),
    .nor_out (nor_res)
  );

  int_alu_shift #(.DATA_W(DATA_W)) u_shift (
    .din  (opnd_a),
    .amt  (shamt),
    .dout (shl_res)
  );

  int_alu_cmp u_cmp (
    .diff_msb    (arith_sum[MSB]),
    .diff_ovf    (arith_ovf),
    .diff_carry  (arith_carry),
    .lt_signed   (lt_s),
    .lt_unsigned (lt_u)
  );

  always_comb begin
    case (op_sel)
      OP_ADD,
      OP_SUB:  result = arith_sum;
      OP_AND:  result = and_res;
      OP_OR:   result = or_res;
      OP_NOR:  result = nor_res;
      OP_SLT:  result = {{(DATA_W-1){1'b0}}, lt_s};
      OP_SLTU: result = {{(DATA_W-1){1'b0}}, lt_u};
      OP_SLL:  result = shl_res;
      default: result = '0;
    endcase
  end

  assign zero = ~|result;

endmodule

// File: rtl/int_alu_chk.sv
`timescale 1ns/1ps
module int_alu_chk
  import int_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SH_W = $clog2(DATA_W)
) (
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] opnd_b,
  input logic [SH_W-1:0]   shamt,
  input logic [3:0]        op_sel,
  input logic [DATA_W-1:0] result,
  input logic              zero
);

  logic [DATA_W-1:0] low_mask;
  assign low_mask = ({{(DATA_W-1){1'b0}}, 1'b1} << shamt) - {{(DATA_W-1){1'b0}}, 1'b1};

  always_comb begin
    if (!$isunknown({op_sel, opnd_a, opnd_b, shamt})) begin
      if (op_sel == OP_SUB)
        AST_SUB_EQUAL: assert (zero == (opnd_a == opnd_b)) else $error("subtract equality flag"); // R8
      if (op_sel == OP_SLT)
        AST_SLT_SIGNED: assert (result == {{(DATA_W-1){1'b0}}, ($signed(opnd_a) < $signed(opnd_b))}) else $error("signed compare"); // R5
      if (op_sel == OP_SLTU)
        AST_SLTU_UNSIGNED: assert (result == {{(DATA_W-1){1'b0}}, (opnd_a < opnd_b)}) else $error("unsigned compare"); // R6
      if (op_sel == OP_SLL)
        AST_SLL_LOW_ZERO: assert ((result & low_mask) == '0) else $error("shift fill"); // R7
      if (op_sel == OP_NOR && opnd_b == '0)
        AST_NOR_INVERT: assert (result == ~opnd_a) else $error("nor as invert"); // R4
      if (op_sel > OP_SLL)
        AST_UNUSED_CODE: assert (zero && result == '0) else $error("unused code"); // R9
    end
  end

endmodule

bind int_alu int_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .opnd_a (opnd_a),
  .opnd_b (opnd_b),
  .shamt  (shamt),
  .op_sel (op_sel),
  .result (result),
  .zero   (zero)
);

// File: tb/int_alu_test.sv
`timescale 1ns/1ps
module int_alu_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] a, b;
  logic [4:0]  sh;
  logic [3:0]  op;
  logic [31:0] res;
  logic        zf;
  int          n_checks = 0;
  int          n_errors = 0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  int_alu uut (
    .opnd_a (a),
    .opnd_b (b),
    .shamt  (sh),
    .op_sel (op),
    .result (res),
    .zero   (zf)
  );

  typedef struct packed {
    logic [3:0]  op;
    logic [4:0]  sh;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [0:NV-1] = '{
    '{4'd0, 5'd0,  32'h7FFFFFFF, 32'h00000001, 32'h80000000},
    '{4'd0, 5'd31, 32'hFFFFFFFF, 32'h00000001, 32'h00000000},
    '{4'd1, 5'd0,  32'h00000005, 32'h00000007, 32'hFFFFFFFE},
    '{4'd1, 5'd9,  32'h12345678, 32'h12345678, 32'h00000000},
    '{4'd2, 5'd0,  32'h00003C00, 32'h00000DC0, 32'h00000C00},
    '{4'd2, 5'd0,  32'hF0F0F0F0, 32'h0F0F0F0F, 32'h00000000},
    '{4'd3, 5'd3,  32'h00003C00, 32'h00000DC0, 32'h00003DC0},
    '{4'd4, 5'd0,  32'h00003C00, 32'h00000000, 32'hFFFFC3FF},
    '{4'd4, 5'd0,  32'hFFFF0000, 32'h0000FFFF, 32'h00000000},
    '{4'd5, 5'd0,  32'hFFFFFFFF, 32'h00000001, 32'h00000001},
    '{4'd5, 5'd0,  32'h80000000, 32'h7FFFFFFF, 32'h00000001},
    '{4'd5, 5'd0,  32'h7FFFFFFF, 32'h80000000, 32'h00000000},
    '{4'd5, 5'd0,  32'h00000005, 32'h00000005, 32'h00000000},
    '{4'd6, 5'd0,  32'hFFFFFFFF, 32'h00000001, 32'h00000000},
    '{4'd6, 5'd0,  32'h80000000, 32'h7FFFFFFF, 32'h00000000},
    '{4'd6, 5'd0,  32'h00000001, 32'hFFFFFFFF, 32'h00000001},
    '{4'd7, 5'd31, 32'h00000003, 32'hFFFFFFFF, 32'h80000000},
    '{4'd7, 5'd4,  32'h0F00000F, 32'h00000000, 32'hF00000F0},
    '{4'd7, 5'd0,  32'hDEADBEEF, 32'h12345678, 32'hDEADBEEF},
    '{4'd8, 5'd0,  32'hFFFFFFFF, 32'h00000001, 32'h00000000},
    '{4'd15, 5'd7, 32'h7FFFFFFF, 32'h7FFFFFFF, 32'h00000000},
    '{4'd3, 5'd31, 32'h00000000, 32'h00000000, 32'h00000000}
  };

  function automatic string req_of(input logic [3:0] code);
    case (code)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2, 4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      default: return "R9";
    endcase
  endfunction

  // Reference restated from the requirements.
  function automatic logic [31:0] model(input logic [3:0] code, input logic [31:0] x,
                                        input logic [31:0] y, input logic [4:0] s);
    case (code)
      4'd0: return x + y;
      4'd1: return x - y;
      4'd2: return x & y;
      4'd3: return x | y;
      4'd4: return ~(x | y);
      4'd5: return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      4'd6: return (x < y) ? 32'd1 : 32'd0;
      4'd7: return x << s;
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] got_r, input logic [31:0] exp_r,
                       input logic got_z, input logic exp_z);
    n_checks++;
    if (got_r !== exp_r || got_z !== exp_z) begin
      n_errors++;
      $display("FAIL %s op=%0d a=%h b=%h sh=%0d: result=%h zero=%b expected result=%h zero=%b",
               tag, op, a, b, sh, got_r, got_z, exp_r, exp_z);
    end
  endtask

  task automatic apply(input logic [3:0] c, input logic [31:0] x, input logic [31:0] y,
                       input logic [4:0] s);
    @(negedge clk);
    op = c; a = x; b = y; sh = s;
    #1;
  endtask

  initial begin
    op = 4'd0; a = '0; b = '0; sh = '0;
    repeat (4) @(posedge clk);
    rst = 1'b0;
    #1;
    // Reset state: zero operands give a zero result and a raised flag (R1, R8).
    check("R8", res, 32'd0, zf, 1'b1);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i].op, VEC[i].a, VEC[i].b, VEC[i].sh);
      check(req_of(VEC[i].op), res, VEC[i].exp, zf, VEC[i].exp == 32'd0);
    end

    // R8: subtract flag for equal and unequal operands.
    apply(4'd1, 32'hCAFEF00D, 32'hCAFEF00D, 5'd0);
    check("R8", res, 32'd0, zf, 1'b1);
    apply(4'd1, 32'hCAFEF00D, 32'hCAFEF00C, 5'd0);
    check("R8", res, 32'd1, zf, 1'b0);

    // R10: shamt changes nothing outside the shift code.
    for (int c = 0; c < 7; c++) begin
      apply(4'(c), 32'h89ABCDEF, 32'h13579BDF, 5'd0);
      begin
        logic [31:0] base;
        base = res;
        apply(4'(c), 32'h89ABCDEF, 32'h13579BDF, 5'd17);
        check("R10", res, base, zf, base == 32'd0);
      end
    end

    // R7: second operand has no effect on the shift.
    apply(4'd7, 32'h00000001, 32'h00000000, 5'd13);
    check("R7", res, 32'h00002000, zf, 1'b0);
    apply(4'd7, 32'h00000001, 32'hFFFFFFFF, 5'd13);
    check("R7", res, 32'h00002000, zf, 1'b0);

    // Random operands, all codes, a quarter with equal operands.
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] x, y, e;
      logic [3:0]  c;
      logic [4:0]  s;
      x = $urandom;
      y = ($urandom % 4 == 0) ? x : $urandom;
      if ($urandom % 8 == 0) x = 32'h80000000;
      if ($urandom % 8 == 0) y = 32'h7FFFFFFF;
      c = 4'($urandom % 16);
      s = 5'($urandom);
      e = model(c, x, y, s);
      apply(c, x, y, s);
      check(req_of(c), res, e, zf, e == 32'd0);
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    finished = 1'b1;
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule